// File: doc/BRIEF.md
# Programmable Horizontal Display Timing Generator

This block produces the horizontal timing of an LCD scanout engine. A pixel-clock counter runs from zero up to a programmable line total and then wraps. Seven absolute position registers, each compared for equality against the counter, move a latched display phase through sync, back porch, left border, image, right border, an inert phase and front porch. From that phase the block drives the sync level, a pixel-push enable, an image-active flag and a border-active flag. A one-clock line-end strobe advances an external vertical counter. A border colour word is passed straight through.

Software programs the positions through a single-cycle write port. Writes land in a shadow copy that becomes active only when the counter wraps, so a line is always timed by a single consistent set of values. Register orderings outside the recommended chain still give defined results: simultaneous compares resolve by phase order, and a left-border position met before the back porch collapses the back porch to zero length.

Top module: `hline_timer`

## Requirements
- R1: While reset is held and in the first cycle after it, `hsync`, `push_en`, `image_act`, `border_act` and `line_end` are 0 (the phase rests in front porch) and `border_color` equals the `DEF_COLOR` parameter.
- R2: The counter counts 0,1,...,T where T is the active line total (address 0) and then returns to 0, so a line lasts T+1 clocks; `line_end` is high for exactly the one clock in which the counter is 0 after a wrap.
- R3: When the counter equals a position register at clock edge n, the outputs show the new phase from the cycle after edge n. `hsync` is high from the cycle after the sync position (address 1) through the cycle in which the counter equals the back-porch position (address 2), which is (back - sync) clocks.
- R4: If the back-porch position equals the sync position, `hsync` never asserts.
- R5: During back porch and front porch (front porch entered at the address 6 position), `push_en`, `image_act` and `border_act` are all 0. `hsync` and `push_en` are never high together.
- R6: The left-border position (address 3) sets `push_en` and `border_act`. If that position is met before the back-porch position in the line, no back porch occurs and the border starts at the back-porch position.
- R7: Address 4 holds the image start in bits [11:0] and the image end in bits [27:16]. Between them `image_act` and `push_en` are high and `border_act` is low. From the image end until front porch, `border_act` and `push_en` are high.
- R8: The inert position (address 5) has no visible effect: outputs keep showing the right border across it.
- R9: When several positions match on the same clock, the phase later in the order sync, back porch, left border, image, right border, inert, front porch wins.
- R10: Writes (`wr_en` high at a clock edge) go to a shadow copy, which becomes active at the edge where the counter wraps. A write made partway through a line does not change the timing of that line.
- R11: Only the low 12 bits of each position field are used. Bits [15:12] of addresses 1, 2, 3, 5 and 6, and bits [15:12] and [31:28] of address 4, are ignored.
- R12: The colour written to address 7 appears on `border_color` from the first cycle of the next line. Before that cycle the output keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 total, 1 sync, 2 back porch, 3 left border, 4 image window, 5 inert, 6 front porch, 7 colour) |
| wr_data | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync level |
| push_en | output | 1 | Pixels are pushed to the panel |
| image_act | output | 1 | Image data is being requested |
| border_act | output | 1 | Border colour is being shown |
| line_end | output | 1 | One-clock strobe at the start of each new line |
| border_color | output | 24 | Active border colour |

## Verification
A wrong latched phase shows as a wrong output level from the cycle after the faulty compare, and it stays wrong until the next matching position. So a per-line count of sync, image, border and push cycles reveals it within one line. A miscounted or wrongly wrapped counter moves every `line_end` and changes the line length at once. A shadow copy that leaks into the active registers changes the line in which the write is made, instead of the next one. The bench sweeps the sync position and width over a small line and checks each configuration against per-line counts worked out by arithmetic. It also runs a cycle-accurate model that compares every output in every cycle.

// File: rtl/htg_pkg.sv
package htg_pkg;

   // Display phases, numbered in their precedence order (later wins).
   typedef enum logic [2:0] {
      PH_SYNC  = 3'd0,
      PH_BACK  = 3'd1,
      PH_LEFT  = 3'd2,
      PH_IMAGE = 3'd3,
      PH_RIGHT = 3'd4,
      PH_INERT = 3'd5,
      PH_FRONT = 3'd6
   } phase_e;

   // Number of position compares; compare k leads to phase k.
   localparam int unsigned NUM_EVT = 7;

   // Register addresses
   localparam logic [2:0] A_TOTAL  = 3'd0;
   localparam logic [2:0] A_SYNC   = 3'd1;
   localparam logic [2:0] A_BACK   = 3'd2;
   localparam logic [2:0] A_LEFT   = 3'd3;
   localparam logic [2:0] A_WINDOW = 3'd4;
   localparam logic [2:0] A_INERT  = 3'd5;
   localparam logic [2:0] A_FRONT  = 3'd6;
   localparam logic [2:0] A_COLOR  = 3'd7;

   // Half-word offset of the image end field inside the window word
   localparam int unsigned HALF_OFS = 16;

endpackage

// File: rtl/htg_regbank.sv
module htg_regbank
   import htg_pkg::*;
#(
   parameter int unsigned CNT_W         = 12,
   parameter int unsigned COLOR_W       = 24,
   parameter int unsigned DEF_TOTAL     = 449,
   parameter int unsigned DEF_SYNC      = 2,
   parameter int unsigned DEF_BACK      = 20,
   parameter int unsigned DEF_LEFT      = 20,
   parameter int unsigned DEF_IMG_START = 40,
   parameter int unsigned DEF_IMG_END   = 440,
   parameter int unsigned DEF_INERT     = 444,
   parameter int unsigned DEF_FRONT     = 446,
   parameter int unsigned DEF_COLOR     = 0
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic                             wr_en,
   input  logic [2:0]                       wr_addr,
   input  logic [31:0]                      wr_data,
   input  logic                             load,
   output logic [CNT_W-1:0]                 total,
   output logic [NUM_EVT-1:0][CNT_W-1:0]    evt_pos,
   output logic [COLOR_W-1:0]               color
);

   localparam logic [CNT_W-1:0]   RST_TOTAL = CNT_W'(DEF_TOTAL);
   localparam logic [COLOR_W-1:0] RST_COLOR = COLOR_W'(DEF_COLOR);

   function automatic logic [CNT_W-1:0] def_pos(input int unsigned k);
      case (k)
         0:       def_pos = CNT_W'(DEF_SYNC);
         1:       def_pos = CNT_W'(DEF_BACK);
         2:       def_pos = CNT_W'(DEF_LEFT);
         3:       def_pos = CNT_W'(DEF_IMG_START);
         4:       def_pos = CNT_W'(DEF_IMG_END);
         5:       def_pos = CNT_W'(DEF_INERT);
         default: def_pos = CNT_W'(DEF_FRONT);
      endcase
   endfunction

   logic [CNT_W-1:0]              sh_total;
   logic [NUM_EVT-1:0][CNT_W-1:0] sh_pos;
   logic [COLOR_W-1:0]            sh_color;

   logic [CNT_W-1:0] lo_field;
   logic [CNT_W-1:0] hi_field;
   logic             wr_unused;

   assign lo_field  = wr_data[CNT_W-1:0];
   assign hi_field  = wr_data[HALF_OFS +: CNT_W];
   assign wr_unused = ^wr_data;

   // Shadow copy: written at any time
   always_ff @(posedge clk) begin
      if (rst) begin
         sh_total <= RST_TOTAL;
         sh_color <= RST_COLOR;
         for (int k = 0; k < int'(NUM_EVT); k++) sh_pos[k] <= def_pos(k);
      end else if (wr_en) begin
         case (wr_addr)
            A_TOTAL:  sh_total  <= lo_field;
            A_SYNC:   sh_pos[0] <= lo_field;
            A_BACK:   sh_pos[1] <= lo_field;
            A_LEFT:   sh_pos[2] <= lo_field;
            A_WINDOW: begin
               sh_pos[3] <= lo_field;
               sh_pos[4] <= hi_field;
            end
            A_INERT:  sh_pos[5] <= lo_field;
            A_FRONT:  sh_pos[6] <= lo_field;
            default:  sh_color  <= wr_data[COLOR_W-1:0];
         endcase
      end
   end

   // Active copy: follows the shadow only at the line wrap
   always_ff @(posedge clk) begin
      if (rst) begin
         total <= RST_TOTAL;
         color <= RST_COLOR;
         for (int k = 0; k < int'(NUM_EVT); k++) evt_pos[k] <= def_pos(k);
      end else if (load) begin
         total   <= sh_total;
         color   <= sh_color;
         evt_pos <= sh_pos;
      end
   end

   assert_active_frozen_R10: assert property (@(posedge clk) disable iff (rst)
      !$past(load) |-> ($stable(evt_pos) && $stable(total) && $stable(color)))
      else $error("active registers changed away from a line wrap");

   assert_active_follows_R10: assert property (@(posedge clk) disable iff (rst)
      ($past(load) && !$past(rst)) |-> (evt_pos == $past(sh_pos)))
      else $error("active positions did not take the shadow at the wrap");

endmodule

// File: rtl/htg_linecnt.sv
module htg_linecnt #(
   parameter int unsigned CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] total,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap,
   output logic             line_end
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   assign wrap = (cnt == total);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt      <= '0;
         line_end <= 1'b0;
      end else if (wrap) begin
         cnt      <= '0;
         line_end <= 1'b1;
      end else begin
         cnt      <= cnt + ONE;
         line_end <= 1'b0;
      end
   end

   assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
      (cnt != '0) |-> (cnt == $past(cnt) + ONE))
      else $error("counter skipped a value");

   assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (rst)
      line_end |-> (cnt == '0 && $past(cnt) == $past(total)))
      else $error("line end strobe away from the wrap");

   assert_no_overrun_R2: assert property (@(posedge clk) disable iff (rst)
      $past(cnt) == $past(total) && !$past(rst) |-> line_end)
      else $error("counter passed the line total without wrapping");

endmodule

// File: rtl/htg_phase.sv
module htg_phase
   import htg_pkg::*;
#(
   parameter int unsigned CNT_W = 12
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic [CNT_W-1:0]              cnt,
   input  logic [NUM_EVT-1:0][CNT_W-1:0] evt_pos,
   output phase_e                        phase
);

   logic [NUM_EVT-1:0] hit;
   phase_e             nxt;
   logic               left_seen_q;
   logic               left_seen_d;

   // One equality compare per position register
   for (genvar k = 0; k < int'(NUM_EVT); k++) begin : g_cmp
      assign hit[k] = (cnt == evt_pos[k]);
   end

   // Later phases in the order override earlier ones
   always_comb begin
      nxt         = phase;
      left_seen_d = left_seen_q;
      if (hit[0]) nxt = PH_SYNC;
      if (hit[1]) begin
         if (left_seen_d) begin
            nxt         = PH_LEFT;
            left_seen_d = 1'b0;
         end else begin
            nxt = PH_BACK;
         end
      end
      if (hit[2]) begin
         if (nxt == PH_BACK) nxt = PH_LEFT;
         else                left_seen_d = 1'b1;
      end
      if (hit[3]) nxt = PH_IMAGE;
      if (hit[4]) nxt = PH_RIGHT;
      if (hit[5]) nxt = PH_INERT;
      if (hit[6]) nxt = PH_FRONT;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase       <= PH_FRONT;
         left_seen_q <= 1'b0;
      end else begin
         phase       <= nxt;
         left_seen_q <= left_seen_d;
      end
   end

   assert_phase_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(hit) == '0) |-> $stable(phase))
      else $error("phase moved with no matching position");

   assert_front_wins_R9: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(hit[6])) |-> (phase == PH_FRONT))
      else $error("front porch match lost to an earlier phase");

   assert_sync_enter_R3: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(hit[0]) && $past(hit[6:1]) == '0) |-> (phase == PH_SYNC))
      else $error("sync match did not enter sync");

   assert_image_enter_R7: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(hit[3]) && $past(hit[6:4]) == '0) |-> (phase == PH_IMAGE))
      else $error("image start match did not enter image");

endmodule

// File: rtl/hline_timer.sv
module hline_timer
   import htg_pkg::*;
#(
   parameter int unsigned CNT_W         = 12,
   parameter int unsigned COLOR_W       = 24,
   parameter bit          OUT_REG       = 1'b0,
   parameter int unsigned DEF_TOTAL     = 449,
   parameter int unsigned DEF_SYNC      = 2,
   parameter int unsigned DEF_BACK      = 20,
   parameter int unsigned DEF_LEFT      = 20,
   parameter int unsigned DEF_IMG_START = 40,
   parameter int unsigned DEF_IMG_END   = 440,
   parameter int unsigned DEF_INERT     = 444,
   parameter int unsigned DEF_FRONT     = 446,
   parameter int unsigned DEF_COLOR     = 0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               wr_en,
   input  logic [2:0]         wr_addr,
   input  logic [31:0]        wr_data,
   output logic               hsync,
   output logic               push_en,
   output logic               image_act,
   output logic               border_act,
   output logic               line_end,
   output logic [COLOR_W-1:0] border_color
);

   localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

   if (CNT_W < 4 || CNT_W > HALF_OFS) begin : g_bad_cnt_w
      $error("CNT_W must lie between 4 and 16");
   end
   if (COLOR_W < 1 || COLOR_W > 32) begin : g_bad_color_w
      $error("COLOR_W must lie between 1 and 32");
   end
   if (DEF_TOTAL > CNT_MAX || DEF_FRONT > CNT_MAX || DEF_IMG_END > CNT_MAX) begin : g_bad_def
      $error("default positions exceed the counter range");
   end

   logic [CNT_W-1:0]              total;
   logic [NUM_EVT-1:0][CNT_W-1:0] evt_pos;
   logic [CNT_W-1:0]              cnt;
   logic                          wrap;
   logic                          lend_raw;
   phase_e                        phase;

   logic d_sync, d_push, d_image, d_border;

   htg_regbank #(
      .CNT_W(CNT_W), .COLOR_W(COLOR_W), .DEF_TOTAL(DEF_TOTAL),
      .DEF_SYNC(DEF_SYNC), .DEF_BACK(DEF_BACK), .DEF_LEFT(DEF_LEFT),
      .DEF_IMG_START(DEF_IMG_START), .DEF_IMG_END(DEF_IMG_END),
      .DEF_INERT(DEF_INERT), .DEF_FRONT(DEF_FRONT), .DEF_COLOR(DEF_COLOR)
   ) u_regs (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .load(wrap), .total(total), .evt_pos(evt_pos), .color(border_color)
   );

   htg_linecnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .total(total), .cnt(cnt), .wrap(wrap), .line_end(lend_raw)
   );

   htg_phase #(.CNT_W(CNT_W)) u_phase (
      .clk(clk), .rst(rst), .cnt(cnt), .evt_pos(evt_pos), .phase(phase)
   );

   // Phase decode
   always_comb begin
      d_sync   = (phase == PH_SYNC);
      d_image  = (phase == PH_IMAGE);
      d_border = (phase == PH_LEFT) || (phase == PH_RIGHT) || (phase == PH_INERT);
      d_push   = d_image || d_border;
   end

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            hsync      <= 1'b0;
            push_en    <= 1'b0;
            image_act  <= 1'b0;
            border_act <= 1'b0;
            line_end   <= 1'b0;
         end else begin
            hsync      <= d_sync;
            push_en    <= d_push;
            image_act  <= d_image;
            border_act <= d_border;
            line_end   <= lend_raw;
         end
      end
   end else begin : g_out_comb
      assign hsync      = d_sync;
      assign push_en    = d_push;
      assign image_act  = d_image;
      assign border_act = d_border;
      assign line_end   = lend_raw;
   end

   assert_sync_dark_R5: assert property (@(posedge clk) disable iff (rst)
      d_sync |-> !d_push)
      else $error("pixels pushed during sync");

   assert_porch_dark_R5: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_BACK || phase == PH_FRONT) |-> !(d_push || d_image || d_border))
      else $error("porch not blanked");

   assert_image_excl_R7: assert property (@(posedge clk) disable iff (rst)
      d_image |-> (d_push && !d_border))
      else $error("image and border overlap");

   assert_inert_border_R8: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_INERT) |-> (d_border && d_push && !d_image && !d_sync))
      else $error("inert phase changed the visible outputs");

endmodule

// File: tb/sim_hline_timer.sv
`timescale 1ns/1ps
module sim_hline_timer;

   localparam int DEF_COLOR = 24'h123456;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        hsync, push_en, image_act, border_act, line_end;
   logic [23:0] border_color;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   bit cyc_on = 1'b0;

   always #5 clk = ~clk;

   hline_timer #(.DEF_COLOR(DEF_COLOR)) u0 (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .hsync(hsync), .push_en(push_en), .image_act(image_act),
      .border_act(border_act), .line_end(line_end), .border_color(border_color)
   );

   // ---------------- reference model built from the requirements ----------
   int m_cnt, m_ph, m_wrap, m_left;
   int act_tot, sh_tot;
   int act_pos[7];
   int sh_pos[7];
   int act_col, sh_col;
   int defs[7] = '{2, 20, 20, 40, 440, 444, 446};

   always @(posedge clk) begin
      if (rst) begin
         m_cnt = 0; m_ph = 6; m_wrap = 0; m_left = 0;
         act_tot = 449; sh_tot = 449; act_col = DEF_COLOR; sh_col = DEF_COLOR;
         for (int k = 0; k < 7; k++) begin act_pos[k] = defs[k]; sh_pos[k] = defs[k]; end
      end else begin
         int np;
         np = m_ph;
         if (m_cnt == act_pos[0]) np = 0;
         if (m_cnt == act_pos[1]) begin
            if (m_left != 0) begin np = 2; m_left = 0; end else np = 1;
         end
         if (m_cnt == act_pos[2]) begin
            if (np == 1) np = 2; else m_left = 1;
         end
         if (m_cnt == act_pos[3]) np = 3;
         if (m_cnt == act_pos[4]) np = 4;
         if (m_cnt == act_pos[5]) np = 5;
         if (m_cnt == act_pos[6]) np = 6;
         m_ph = np;
         if (m_cnt == act_tot) begin
            m_cnt = 0; m_wrap = 1;
            act_tot = sh_tot; act_col = sh_col;
            for (int k = 0; k < 7; k++) act_pos[k] = sh_pos[k];
         end else begin
            m_cnt = m_cnt + 1; m_wrap = 0;
         end
         if (wr_en) begin
            case (wr_addr)
               3'd0: sh_tot = int'(wr_data[11:0]);
               3'd1: sh_pos[0] = int'(wr_data[11:0]);
               3'd2: sh_pos[1] = int'(wr_data[11:0]);
               3'd3: sh_pos[2] = int'(wr_data[11:0]);
               3'd4: begin sh_pos[3] = int'(wr_data[11:0]); sh_pos[4] = int'(wr_data[27:16]); end
               3'd5: sh_pos[5] = int'(wr_data[11:0]);
               3'd6: sh_pos[6] = int'(wr_data[11:0]);
               default: sh_col = int'(wr_data[23:0]);
            endcase
         end
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (cyc_on && !done) begin
         chk("R3", "hsync", int'(hsync), int'(m_ph == 0));
         chk("R5", "push_en", int'(push_en), int'(m_ph >= 2 && m_ph <= 5));
         chk("R7", "image_act", int'(image_act), int'(m_ph == 3));
         chk("R6", "border_act", int'(border_act), int'(m_ph == 2 || m_ph == 4 || m_ph == 5));
         chk("R2", "line_end", int'(line_end), m_wrap);
         chk("R12", "border_color", int'(border_color), act_col);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wreg(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic cfg(input int tot, input int s, input int b, input int l,
                      input int is, input int ie, input int inr, input int f);
      wreg(3'd0, 32'(tot));
      wreg(3'd1, 32'(s));
      wreg(3'd2, 32'(b));
      wreg(3'd3, 32'(l));
      wreg(3'd4, (32'(ie) << 16) | 32'(is));
      wreg(3'd5, 32'(inr));
      wreg(3'd6, 32'(f));
   endtask

   int ln_len, ln_hs, ln_img, ln_brd, ln_push;

   task automatic measure();
      bit fin;
      while (!line_end) @(negedge clk);
      ln_len = 0; ln_hs = 0; ln_img = 0; ln_brd = 0; ln_push = 0;
      fin = 1'b0;
      while (!fin) begin
         ln_len++;
         ln_hs   += int'(hsync);
         ln_img  += int'(image_act);
         ln_brd  += int'(border_act);
         ln_push += int'(push_en);
         @(negedge clk);
         if (line_end) fin = 1'b1;
      end
   endtask

   task automatic steady();
      measure();
      measure();
   endtask

   // ---------------- test sequence ----------------
   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state
      chk("R1", "hsync in reset", int'(hsync), 0);
      chk("R1", "push_en in reset", int'(push_en), 0);
      chk("R1", "image_act in reset", int'(image_act), 0);
      chk("R1", "border_act in reset", int'(border_act), 0);
      chk("R1", "line_end in reset", int'(line_end), 0);
      chk("R1", "colour in reset", int'(border_color), DEF_COLOR);
      rst = 1'b0;
      @(negedge clk);
      chk("R1", "outputs after reset", int'({hsync, push_en, image_act, border_act, line_end}), 0);
      cyc_on = 1'b1;

      // R2: default line length
      steady();
      chk("R2", "default line length", ln_len, 450);

      // Near-exhaustive sweep of sync position and width (R2 R3 R5 R6 R7)
      for (int s = 0; s < 6; s++) begin
         for (int w = 1; w < 5; w++) begin
            cfg(39, s, s + w, s + w + 2, s + w + 5, 30, 32, 35);
            steady();
            chk("R2", "sweep line length", ln_len, 40);
            chk("R3", "sweep sync width", ln_hs, w);
            chk("R7", "sweep image width", ln_img, 30 - (s + w + 5));
            chk("R6", "sweep border width", ln_brd, 3 + (35 - 30));
            chk("R5", "sweep push width", ln_push, 35 - (s + w + 2));
         end
      end

      // R4: back porch equal to sync
      cfg(39, 10, 10, 12, 15, 30, 32, 35);
      steady();
      chk("R4", "sync count with equal positions", ln_hs, 0);

      // R6: left border met before back porch
      cfg(39, 5, 10, 1, 15, 30, 32, 35);
      steady();
      chk("R6", "early left border: border cycles", ln_brd, (15 - 10) + (35 - 30));
      chk("R6", "early left border: push cycles", ln_push, 35 - 10);
      chk("R3", "early left border: sync cycles", ln_hs, 5);

      // R9: left border and image start on the same count
      cfg(39, 5, 10, 15, 15, 30, 32, 35);
      steady();
      chk("R9", "tie: border cycles", ln_brd, 35 - 30);
      chk("R9", "tie: image cycles", ln_img, 15);
      // R9: front porch on the sync count
      cfg(39, 5, 10, 12, 15, 30, 32, 5);
      steady();
      chk("R9", "front over sync: sync cycles", ln_hs, 0);

      // R8: moving the inert position changes nothing
      for (int p = 30; p < 36; p++) begin
         cfg(39, 5, 10, 12, 15, 30, p, 35);
         steady();
         chk("R8", "inert: border cycles", ln_brd, 3 + 5);
         chk("R8", "inert: push cycles", ln_push, 23);
      end

      // R11: upper bits of each field are ignored
      wreg(3'd0, 32'h0000_F027);
      wreg(3'd1, 32'h0000_A005);
      wreg(3'd2, 32'h0000_700A);
      wreg(3'd3, 32'h0000_300C);
      wreg(3'd4, 32'hF01E_F00F);
      wreg(3'd5, 32'h0000_9020);
      wreg(3'd6, 32'h0000_5023);
      steady();
      chk("R11", "masked line length", ln_len, 40);
      chk("R11", "masked sync cycles", ln_hs, 5);
      chk("R11", "masked image cycles", ln_img, 15);
      chk("R11", "masked push cycles", ln_push, 23);

      // R10: writes in mid-line do not affect the current line
      steady();
      wreg(3'd1, 32'd2);
      wreg(3'd2, 32'd8);
      begin
         int hs_rest;
         hs_rest = 0;
         while (!line_end) begin
            hs_rest += int'(hsync);
            @(negedge clk);
         end
         chk("R10", "sync cycles in line of the write", hs_rest, 5);
      end
      measure();
      measure();
      chk("R10", "sync cycles after the wrap", ln_hs, 6);

      // R12: colour change waits for the line start
      while (!line_end) @(negedge clk);
      repeat (5) @(negedge clk);
      wreg(3'd7, 32'h00AB_CDEF);
      chk("R12", "colour before line start", int'(border_color), DEF_COLOR);
      while (!line_end) @(negedge clk);
      chk("R12", "colour at line start", int'(border_color), 24'hABCDEF);

      // R2: a second line total
      cfg(25, 1, 4, 6, 8, 18, 20, 22);
      steady();
      chk("R2", "short line length", ln_len, 26);
      chk("R7", "short image cycles", ln_img, 10);

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      #1000000;
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule